// File: doc/BRIEF.md
# Flash Command Write Sequencer

This block sits between a host register bus and a flash operation engine. The host starts a command in three strict steps. First it writes an address and data word into the array space. Then it writes a command code to the command register. Last, it writes 1 to the buffer-empty bit of the status register, which launches the command. The address, data and command are held in holding registers. A launched command goes to the engine at once if the engine is idle. Otherwise it waits in the holding registers behind the active operation, so one command can be queued behind one command that is running.

The engine is a busy counter. Its length is set by a parameter for each command type. The status register shows four flags: buffer empty, command complete, access error and protection violation. Both error flags are cleared by writing 1 to them. A write that breaks the step order, an unknown command code, or a new sequence started while an error flag is set raises the access error and drops the partial sequence. A program or erase command whose address falls in a protected range raises the protection violation, and that command is never launched.

Top module: `fcmd_seq`

## Requirements
- R1: After reset, buf_empty and cmd_done are 1, acc_err, prot_err and op_busy are 0, and the status register (register index 0) reads 8'h03. Status bit positions: bit 0 buffer empty, bit 1 command complete, bit 2 access error, bit 3 protection violation.
- R2: An array write captures bus_addr and bus_wdata into the holding registers, which read back at register index 2 (address) and 3 (data). The command register is index 1. After a launch, op_start pulses for one cycle with op_cmd/op_addr/op_data equal to the held values. Read data appears on bus_rdata in the cycle after bus_rd.
- R3: A launch write (status write with bit 0 = 1 after a valid command) clears buf_empty and cmd_done on the next clock edge. buf_empty returns to 1 when the command passes to the engine.
- R4: A status write with bit 0 = 0 changes no flag and launches nothing. The sequence in progress stays intact and can still be launched.
- R5: A command launched while the engine is busy keeps buf_empty at 0. It is issued only after op_busy falls, and never while op_busy is 1.
- R6: cmd_done sets only once the active command and any queued command have both finished. It stays 0 in the gap between them.
- R7: Register reads and array reads never change flags, holding registers or the sequence state.
- R8: An array write made while a launched command is still queued (buf_empty 0) replaces the queued command. buf_empty returns to 1, and the replaced command is never issued.
- R9: An array write while an address is already held, a command write before an address is held, or a launch before a command is held each set acc_err and abort the sequence.
- R10: Valid codes are 8'h1A program, 8'h2B sector erase, 8'h3C mass erase and 8'h4D erase verify. Any other code sets acc_err and aborts the sequence, so a later launch is also an error.
- R11: An array write while acc_err or prot_err is 1 sets acc_err and does not update the holding registers.
- R12: Program, sector erase or mass erase with a held address in [PROT_LO, PROT_HI] sets prot_err and the command is not launched. Erase verify is allowed in that range, and addresses outside it are allowed.
- R13: Writing 1 to status bit 2 clears acc_err and writing 1 to bit 3 clears prot_err. Writing 0 to those bits leaves them unchanged.
- R14: op_busy stays high for exactly CYC_PROG, CYC_SECT, CYC_MASS or CYC_VRFY cycles for the matching command type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_array | input | 1 | 1 selects the array space, 0 selects registers |
| bus_addr | input | AW | Array address, or register index in bits 1:0 |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| buf_empty | output | 1 | Holding registers can take a new sequence |
| cmd_done | output | 1 | All launched commands have finished |
| acc_err | output | 1 | Access error flag |
| prot_err | output | 1 | Protection violation flag |
| op_start | output | 1 | One-cycle issue pulse to the engine |
| op_cmd | output | 8 | Issued command code |
| op_addr | output | AW | Issued address |
| op_data | output | DW | Issued data |
| op_busy | output | 1 | Engine operation in progress |

## Verification
The assertions assume that bus_wr and bus_rd are never high together, that each strobe lasts one cycle, and that address and data are stable while a strobe is high. They also assume a data width of at least eight bits. Every bus access in the stimulus goes through one write task or one read task. Each task raises exactly one strobe for a single cycle and then idles it, so these conditions hold by construction. Queueing is exercised by launching a second command inside the long mass-erase busy window, and the replacement case cancels a queued command inside that same window.

// File: rtl/fcmd_pkg.sv
`timescale 1ns/1ps
package fcmd_pkg;
  // command codes
  localparam logic [7:0] OP_PROG = 8'h1A;
  localparam logic [7:0] OP_SECT = 8'h2B;
  localparam logic [7:0] OP_MASS = 8'h3C;
  localparam logic [7:0] OP_VRFY = 8'h4D;

  // status bit positions
  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_ACC   = 2;
  localparam int ST_PROT  = 3;

  // register indices
  localparam logic [1:0] RG_STAT = 2'd0;
  localparam logic [1:0] RG_CMD  = 2'd1;
  localparam logic [1:0] RG_ADDR = 2'd2;
  localparam logic [1:0] RG_DATA = 2'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_CMD} seq_e;

  function automatic logic code_ok(input logic [7:0] c);
    return (c == OP_PROG) || (c == OP_SECT) || (c == OP_MASS) || (c == OP_VRFY);
  endfunction
endpackage

// File: rtl/fcmd_seq_fsm.sv
`timescale 1ns/1ps
module fcmd_seq_fsm import fcmd_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] PROT_LO = 'hF000,
  parameter logic [AW-1:0] PROT_HI = 'hFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_array,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data,
  output logic [7:0]    hold_cmd,
  output logic          launch,
  output logic          cancel,
  output logic          acc_err,
  output logic          prot_err
);
  seq_e state_q, state_n;
  logic set_acc, set_prot, cap, store;
  logic arr_wr, cmd_wr, st_wr, go, err_any, in_prot;
  logic [7:0] code;

  assign arr_wr  = bus_wr && bus_array;
  assign cmd_wr  = bus_wr && !bus_array && (bus_addr[1:0] == RG_CMD);
  assign st_wr   = bus_wr && !bus_array && (bus_addr[1:0] == RG_STAT);
  assign go      = st_wr && bus_wdata[ST_EMPTY];
  assign err_any = acc_err || prot_err;
  assign code    = bus_wdata[7:0];
  assign in_prot = (hold_addr >= PROT_LO) && (hold_addr <= PROT_HI);

  always_comb begin
    state_n  = state_q;
    set_acc  = 1'b0;
    set_prot = 1'b0;
    cap      = 1'b0;
    store    = 1'b0;
    launch   = 1'b0;
    if (arr_wr) begin
      if (state_q == SQ_IDLE && !err_any) begin
        cap     = 1'b1;
        state_n = SQ_ADDR;
      end else begin
        set_acc = 1'b1;
        state_n = SQ_IDLE;
      end
    end else if (cmd_wr) begin
      if (state_q != SQ_ADDR || !code_ok(code)) begin
        set_acc = 1'b1;
        state_n = SQ_IDLE;
      end else if (code != OP_VRFY && in_prot) begin
        set_prot = 1'b1;
        state_n  = SQ_IDLE;
      end else begin
        store   = 1'b1;
        state_n = SQ_CMD;
      end
    end else if (go) begin
      if (state_q == SQ_CMD) launch = 1'b1;
      else                   set_acc = 1'b1;
      state_n = SQ_IDLE;
    end
  end

  assign cancel = cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      acc_err   <= 1'b0;
      prot_err  <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_cmd  <= '0;
    end else begin
      state_q  <= state_n;
      acc_err  <= set_acc  || (acc_err  && !(st_wr && bus_wdata[ST_ACC]));
      prot_err <= set_prot || (prot_err && !(st_wr && bus_wdata[ST_PROT]));
      if (cap) begin
        hold_addr <= bus_addr;
        hold_data <= bus_wdata;
      end
      if (store) hold_cmd <= code;
    end
  end
endmodule

// File: rtl/fcmd_engine.sv
`timescale 1ns/1ps
module fcmd_engine import fcmd_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CYC_PROG = 4,
  parameter int CYC_SECT = 12,
  parameter int CYC_MASS = 20,
  parameter int CYC_VRFY = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          cancel,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  input  logic [7:0]    hold_cmd,
  output logic          buf_empty,
  output logic          cmd_done,
  output logic          op_start,
  output logic [7:0]    op_cmd,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_busy
);
  localparam int M1   = (CYC_PROG > CYC_SECT) ? CYC_PROG : CYC_SECT;
  localparam int M2   = (CYC_MASS > CYC_VRFY) ? CYC_MASS : CYC_VRFY;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  logic          pending_q;
  logic [CW-1:0] cnt_q;
  logic          issue, fin;

  function automatic logic [CW-1:0] load_of(input logic [7:0] c);
    case (c)
      OP_PROG: return CW'(CYC_PROG - 1);
      OP_SECT: return CW'(CYC_SECT - 1);
      OP_MASS: return CW'(CYC_MASS - 1);
      default: return CW'(CYC_VRFY - 1);
    endcase
  endfunction

  assign issue     = pending_q && !op_busy;
  assign fin       = op_busy && (cnt_q == '0);
  assign buf_empty = !pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      op_busy   <= 1'b0;
      cnt_q     <= '0;
      cmd_done  <= 1'b1;
      op_start  <= 1'b0;
      op_cmd    <= '0;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      op_start <= issue;
      if (launch)              pending_q <= 1'b1;
      else if (issue || cancel) pending_q <= 1'b0;

      if (issue) begin
        op_busy <= 1'b1;
        cnt_q   <= load_of(hold_cmd);
        op_cmd  <= hold_cmd;
        op_addr <= hold_addr;
        op_data <= hold_data;
      end else if (fin) begin
        op_busy <= 1'b0;
      end else if (op_busy) begin
        cnt_q <= cnt_q - 1'b1;
      end

      if (launch)                            cmd_done <= 1'b0;
      else if (fin && (!pending_q || cancel)) cmd_done <= 1'b1;
    end
  end
endmodule

// File: rtl/fcmd_rdmux.sv
`timescale 1ns/1ps
module fcmd_rdmux import fcmd_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rd,
  input  logic          bus_array,
  input  logic [1:0]    reg_idx,
  input  logic [7:0]    status,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  input  logic [7:0]    hold_cmd,
  output logic [DW-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_array) begin
        bus_rdata <= '0;
      end else begin
        case (reg_idx)
          RG_STAT: bus_rdata <= DW'(status);
          RG_CMD:  bus_rdata <= DW'(hold_cmd);
          RG_ADDR: bus_rdata <= DW'(hold_addr);
          default: bus_rdata <= hold_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/fcmd_seq.sv
`timescale 1ns/1ps
module fcmd_seq import fcmd_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] PROT_LO = 'hF000,
  parameter logic [AW-1:0] PROT_HI = 'hFFFF,
  parameter int CYC_PROG = 4,
  parameter int CYC_SECT = 12,
  parameter int CYC_MASS = 20,
  parameter int CYC_VRFY = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_array,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          buf_empty,
  output logic          cmd_done,
  output logic          acc_err,
  output logic          prot_err,
  output logic          op_start,
  output logic [7:0]    op_cmd,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_busy
);
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic [7:0]    hold_cmd;
  logic          launch, cancel;
  logic [7:0]    status;

  always_comb begin
    status           = '0;
    status[ST_EMPTY] = buf_empty;
    status[ST_DONE]  = cmd_done;
    status[ST_ACC]   = acc_err;
    status[ST_PROT]  = prot_err;
  end

  fcmd_seq_fsm #(.AW(AW), .DW(DW), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_fsm (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_array(bus_array),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .hold_addr(hold_addr), .hold_data(hold_data), .hold_cmd(hold_cmd),
    .launch(launch), .cancel(cancel), .acc_err(acc_err), .prot_err(prot_err)
  );

  fcmd_engine #(.AW(AW), .DW(DW), .CYC_PROG(CYC_PROG), .CYC_SECT(CYC_SECT),
                .CYC_MASS(CYC_MASS), .CYC_VRFY(CYC_VRFY)) u_eng (
    .clk(clk), .rst(rst), .launch(launch), .cancel(cancel),
    .hold_addr(hold_addr), .hold_data(hold_data), .hold_cmd(hold_cmd),
    .buf_empty(buf_empty), .cmd_done(cmd_done), .op_start(op_start),
    .op_cmd(op_cmd), .op_addr(op_addr), .op_data(op_data), .op_busy(op_busy)
  );

  fcmd_rdmux #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_array(bus_array),
    .reg_idx(bus_addr[1:0]), .status(status), .hold_addr(hold_addr),
    .hold_data(hold_data), .hold_cmd(hold_cmd), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/fcmd_seq_chk.sv
`timescale 1ns/1ps
module fcmd_seq_chk (
  input logic clk,
  input logic rst,
  input logic buf_empty,
  input logic cmd_done,
  input logic op_start,
  input logic op_busy
);
  // R5: an issue only drains a queued command
  p_issue_pending_r5: assert property (@(posedge clk) disable iff (rst)
    op_start |-> $past(!buf_empty));
  // R5: never issued over an active operation
  p_issue_idle_r5: assert property (@(posedge clk) disable iff (rst)
    op_start |-> !$past(op_busy));
  // R6: complete means nothing active and nothing queued
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> (buf_empty && !op_busy));
  // R3: a launch clears the complete flag together with buffer empty
  p_launch_clears_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_empty) |-> !cmd_done);
  // R2: issue is a single-cycle pulse
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);
  // R14: the engine is busy from the issue cycle on
  p_start_busy_r14: assert property (@(posedge clk) disable iff (rst)
    op_start |-> op_busy);
endmodule

bind fcmd_seq fcmd_seq_chk u_chk (.*);

// File: tb/sim_fcmd_seq.sv
`timescale 1ns/1ps
module sim_fcmd_seq;
  localparam logic [7:0] C_PROG = 8'h1A, C_SECT = 8'h2B, C_MASS = 8'h3C, C_VRFY = 8'h4D;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bus_array = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic buf_empty, cmd_done, acc_err, prot_err, op_start, op_busy;
  logic [7:0] op_cmd;
  logic [15:0] op_addr, op_data;

  always #2.5 clk = ~clk;

  fcmd_seq u0 (.*);

  typedef struct {logic [7:0] cmd; logic [15:0] addr; logic [15:0] data; int cyc;} item_t;
  item_t expq[$];
  int n_chk = 0, n_bad = 0;
  bit tracking = 0;
  int cur_len = 0, cur_exp = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cyc_of(input logic [7:0] c);
    case (c)
      C_PROG: return 4;
      C_SECT: return 12;
      C_MASS: return 20;
      default: return 3;
    endcase
  endfunction

  task automatic push(input logic [7:0] c, input logic [15:0] a, input logic [15:0] d);
    item_t it;
    it.cmd = c; it.addr = a; it.data = d; it.cyc = cyc_of(c);
    expq.push_back(it);
  endtask

  // monitor: compares issued operations and busy length
  always @(negedge clk) begin
    if (!rst) begin
      if (op_start) begin
        n_chk++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R8 unexpected issue actual=%h expected=none", op_cmd);
        end else begin
          item_t it;
          it = expq.pop_front();
          n_chk--;
          check("R2 op_cmd", op_cmd, it.cmd);
          check("R2 op_addr", op_addr, it.addr);
          check("R2 op_data", op_data, it.data);
          tracking = 1; cur_len = 1; cur_exp = it.cyc;
        end
      end else if (tracking) begin
        if (op_busy) cur_len++;
        else begin
          check("R14 busy length", cur_len, cur_exp);
          tracking = 0;
        end
      end
    end
  end

  task automatic wr(input bit arr, input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_array = arr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0; bus_array = 0;
  endtask

  task automatic rd(input bit arr, input logic [15:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    bus_rd = 1; bus_array = arr; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 0; bus_array = 0;
    v = bus_rdata;
  endtask

  task automatic seq(input logic [15:0] a, input logic [15:0] d, input logic [7:0] c);
    wr(1, a, d);
    wr(0, 16'd1, {8'h00, c});
  endtask

  task automatic go();
    wr(0, 16'd0, 16'h0001);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (cmd_done && expq.size() == 0 && !tracking) break;
    end
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 buf_empty", buf_empty, 1);
    check("R1 cmd_done", cmd_done, 1);
    check("R1 errors", {acc_err, prot_err}, 0);
    check("R1 op_busy", op_busy, 0);
    rd(0, 16'd0, v);
    check("R1 status read", v, 16'h0003);

    // R2/R3 single program
    wr(1, 16'h0120, 16'hBEEF);
    rd(0, 16'd2, v); check("R2 held addr", v, 16'h0120);
    rd(0, 16'd3, v); check("R2 held data", v, 16'hBEEF);
    wr(0, 16'd1, C_PROG);
    push(C_PROG, 16'h0120, 16'hBEEF);
    go();
    @(negedge clk);
    check("R3 buf_empty after launch", buf_empty, 0);
    check("R3 cmd_done after launch", cmd_done, 0);
    @(negedge clk);
    check("R3 buf_empty after issue", buf_empty, 1);
    wait_done();

    // R4 write of 0 to the launch bit
    seq(16'h0200, 16'h1111, C_SECT);
    wr(0, 16'd0, 16'h0000);
    @(negedge clk);
    check("R4 flags unchanged", {prot_err, acc_err, cmd_done, buf_empty}, 4'b0011);
    repeat (5) @(negedge clk);
    push(C_SECT, 16'h0200, 16'h1111);
    go();
    wait_done();

    // R5/R6 queued behind active
    push(C_MASS, 16'h0300, 16'h2222);
    seq(16'h0300, 16'h2222, C_MASS); go();
    push(C_PROG, 16'h0310, 16'h3333);
    seq(16'h0310, 16'h3333, C_PROG); go();
    @(negedge clk);
    check("R5 queued keeps buf_empty low", buf_empty, 0);
    while (op_busy) @(negedge clk);
    check("R6 done low in gap", cmd_done, 0);
    wait_done();
    check("R6 done after both", cmd_done, 1);

    // R7 reads during a sequence
    wr(1, 16'h0400, 16'h4444);
    rd(0, 16'd0, v); check("R7 status read mid-sequence", v, 16'h0003);
    rd(1, 16'h0999, v);
    rd(0, 16'd2, v); check("R7 held addr kept", v, 16'h0400);
    wr(0, 16'd1, C_VRFY);
    rd(0, 16'd1, v); check("R7 cmd read", v, 16'h004D);
    push(C_VRFY, 16'h0400, 16'h4444);
    go();
    wait_done();
    check("R7 no error", acc_err, 0);

    // R8 replace queued command
    push(C_MASS, 16'h0500, 16'h5555);
    seq(16'h0500, 16'h5555, C_MASS); go();
    seq(16'h0510, 16'h6666, C_PROG); go();
    wr(1, 16'h0520, 16'h7777);
    @(negedge clk);
    check("R8 buf_empty after replace", buf_empty, 1);
    wr(0, 16'd1, C_SECT);
    push(C_SECT, 16'h0520, 16'h7777);
    go();
    wait_done();

    // R9 / R13 order errors and clearing
    wr(1, 16'h0600, 16'd1);
    wr(1, 16'h0601, 16'd2);
    @(negedge clk); check("R9 double array write", acc_err, 1);
    wr(0, 16'd0, 16'h0000);
    @(negedge clk); check("R13 write 0 keeps acc_err", acc_err, 1);
    wr(0, 16'd0, 16'h0004);
    @(negedge clk); check("R13 clear acc_err", acc_err, 0);
    go();
    @(negedge clk); check("R9 launch while idle", {acc_err, buf_empty}, 2'b11);
    wr(0, 16'd0, 16'h0004);
    wr(0, 16'd1, C_PROG);
    @(negedge clk); check("R9 command before address", acc_err, 1);
    wr(0, 16'd0, 16'h0004);

    // R10 invalid code
    wr(1, 16'h0700, 16'd3);
    wr(0, 16'd1, 16'h0077);
    @(negedge clk); check("R10 invalid code", acc_err, 1);
    wr(0, 16'd0, 16'h0004);
    go();
    @(negedge clk); check("R10 no launch after abort", {acc_err, buf_empty}, 2'b11);

    // R11 start while error set (acc_err still 1 here)
    wr(1, 16'h0800, 16'd9);
    rd(0, 16'd2, v); check("R11 address not captured", v, 16'h0700);
    wr(0, 16'd0, 16'h0004);

    // R12 protection
    wr(1, 16'hF100, 16'd5);
    wr(0, 16'd1, C_PROG);
    @(negedge clk); check("R12 program in range", {prot_err, acc_err}, 2'b10);
    wr(0, 16'd0, 16'h0008);
    @(negedge clk); check("R13 clear prot_err", prot_err, 0);
    wr(1, 16'hFFFF, 16'd6);
    wr(0, 16'd1, C_MASS);
    @(negedge clk); check("R12 mass erase in range", prot_err, 1);
    wr(0, 16'd0, 16'h0008);
    push(C_VRFY, 16'hF200, 16'h00AA);
    seq(16'hF200, 16'h00AA, C_VRFY); go();
    wait_done();
    push(C_SECT, 16'hEFFF, 16'h00BB);
    seq(16'hEFFF, 16'h00BB, C_SECT); go();
    wait_done();
    check("R12 no prot_err outside range", prot_err, 0);

    repeat (5) @(negedge clk);
    check("R8 all expected issued", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule